// File: doc/BRIEF.md
# Processor Control and Status Word with Interrupt-Enable Save/Restore

This block is the 32-bit control and status word of a processor core. It holds the bit that lets maskable interrupts through, together with a saved copy of that bit. It also holds storage for the power-down, program-cache and data-cache control fields, a saturation status flag, the endian status and two read-only identification bytes. Software reads the whole word and writes it through a move-to/from-control-register port. Each field follows its own access rule: read/write, read-only, or read-and-clear-only.

The core tells the block when it accepts a maskable interrupt and when it executes a return from interrupt. When an interrupt is accepted, the current enable moves into the saved bit and the enable drops to zero, so no second maskable interrupt can be accepted before the core has saved its state. A return copies the saved bit back into the enable. The current enable is also a port, which the interrupt controller uses to gate maskable requests. The core must never raise interrupt-accept and interrupt-return in the same cycle. A simulation check watches for this.

Top module: `core_ctrl_status`

## Requirements
- R1: Output `irq_en_o` always equals bit 0 of `sw_rdata`. Bit 0 = 1 means maskable interrupts are processed, and 0 means they are blocked.
- R2: After a synchronous reset, bits 15:0 of `sw_rdata` read zero, apart from bit 8 (endian status), which follows its pin. `irq_en_o` reads 0.
- R3: A cycle with `irq_take` high loads bit 1 with the old bit 0 and clears bit 0 in one update. This takes priority over a software write to bits 1:0 in the same cycle.
- R4: A cycle with `irq_ret` high copies bit 1 into bit 0 and leaves bit 1 unchanged. This takes priority over a software write to bits 1:0 in the same cycle.
- R5: A software write (`sw_wr` high) stores `sw_wdata` bits 15:10 (power-down), 7:5 (program cache), 4:2 (data cache), 1 (saved enable) and 0 (enable). Each value is visible on `sw_rdata` after that clock edge.
- R6: Bits 31:24 always read parameter `CPU_ID` and bits 23:16 always read parameter `REV_ID`. Writes to those bits have no effect.
- R7: Bit 8 follows input `endian_pin` with no clock delay. Writes to bit 8 have no effect.
- R8: Bit 9 (saturation) is cleared by a software write with `sw_wdata[9]` = 0. A write with a 1 in that bit cannot set it.
- R9: A `sat_set` pulse sets bit 9 at the next edge. It wins over a software clear in the same cycle.
- R10: In a cycle with no write, no `irq_take` and no `irq_ret`, bits 1:0 keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr | input | 1 | Software write strobe for the word |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Current word as software reads it |
| irq_take | input | 1 | Core accepts a maskable interrupt this cycle |
| irq_ret | input | 1 | Core executes a return from interrupt this cycle |
| sat_set | input | 1 | Core reports a saturating result this cycle |
| endian_pin | input | 1 | Endian status to expose in bit 8 |
| irq_en_o | output | 1 | Current maskable interrupt enable |

## Verification
A wrong enable or saved-enable value becomes visible on `irq_en_o` and on `sw_rdata[1:0]` on the first edge after the event that caused it. A lost save only shows later, when a return restores a wrong enable, so the bench runs accept/return pairs with both enable values, including an accept while interrupts are already disabled. Broken priority between the core's events, software writes and saturation setting shows on the word one cycle after the colliding stimulus. For this reason every collision case is checked on the following cycle.

// File: rtl/csr_pkg.sv
package csr_pkg;

    localparam int WORD_W   = 32;
    localparam int ID_W     = 8;
    localparam int PWR_W    = 6;
    localparam int CACHE_W  = 3;

    localparam int EN_BIT   = 0;
    localparam int PREV_BIT = 1;
    localparam int DC_LSB   = 2;
    localparam int PC_LSB   = DC_LSB + CACHE_W;
    localparam int END_BIT  = PC_LSB + CACHE_W;
    localparam int SAT_BIT  = END_BIT + 1;
    localparam int PWR_LSB  = SAT_BIT + 1;

    typedef struct packed {
        logic [ID_W-1:0]    cpu_id;
        logic [ID_W-1:0]    rev_id;
        logic [PWR_W-1:0]   pwr_ctl;
        logic               sat;
        logic               endian;
        logic [CACHE_W-1:0] pcache;
        logic [CACHE_W-1:0] dcache;
        logic               ie_prev;
        logic               ie_en;
    } csr_word_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_WRITE,
        EV_TAKE,
        EV_RET
    } ie_event_e;

    function automatic ie_event_e pick_event(input logic take, input logic ret,
                                             input logic wr);
        if (take)     return EV_TAKE;
        else if (ret) return EV_RET;
        else if (wr)  return EV_WRITE;
        else          return EV_NONE;
    endfunction

endpackage

// File: rtl/csr_ie_ctl.sv
module csr_ie_ctl
    import csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] wbits,
    input  logic       take,
    input  logic       ret,
    output logic       en,
    output logic       prev
);

    ie_event_e ev;

    always_comb begin
        ev = pick_event(take, ret, wr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= 1'b0;
            prev <= 1'b0;
        end else begin
            unique case (ev)
                EV_TAKE: begin
                    prev <= en;
                    en   <= 1'b0;
                end
                EV_RET: begin
                    en   <= prev;
                end
                EV_WRITE: begin
                    en   <= wbits[0];
                    prev <= wbits[1];
                end
                default: begin
                    en   <= en;
                    prev <= prev;
                end
            endcase
        end
    end

endmodule

// File: rtl/csr_sat_flag.sv
module csr_sat_flag (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wbit,
    input  logic set,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (wr && !wbit)
            flag <= 1'b0;
    end

endmodule

// File: rtl/csr_ctl_field.sv
module csr_ctl_field #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr)
            q <= wdata;
    end

endmodule

// File: rtl/core_ctrl_status.sv
module core_ctrl_status
    import csr_pkg::*;
#(
    parameter logic [7:0] CPU_ID = 8'hA5,
    parameter logic [7:0] REV_ID = 8'h3C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_wr,
    input  logic [31:0] sw_wdata,
    output logic [31:0] sw_rdata,
    input  logic        irq_take,
    input  logic        irq_ret,
    input  logic        sat_set,
    input  logic        endian_pin,
    output logic        irq_en_o
);

    logic               ie_en;
    logic               ie_prev;
    logic               sat_q;
    logic [PWR_W-1:0]   pwr_q;
    logic [CACHE_W-1:0] pc_q;
    logic [CACHE_W-1:0] dc_q;
    csr_word_t          word;
    logic               unused_wbits;

    assign unused_wbits = ^{sw_wdata[31:16], sw_wdata[END_BIT]};

    csr_ie_ctl u_ie (
        .clk   (clk),
        .rst   (rst),
        .wr    (sw_wr),
        .wbits ({sw_wdata[PREV_BIT], sw_wdata[EN_BIT]}),
        .take  (irq_take),
        .ret   (irq_ret),
        .en    (ie_en),
        .prev  (ie_prev)
    );

    csr_sat_flag u_sat (
        .clk  (clk),
        .rst  (rst),
        .wr   (sw_wr),
        .wbit (sw_wdata[SAT_BIT]),
        .set  (sat_set),
        .flag (sat_q)
    );

    csr_ctl_field #(.W(PWR_W)) u_pwr (
        .clk   (clk),
        .rst   (rst),
        .wr    (sw_wr),
        .wdata (sw_wdata[PWR_LSB +: PWR_W]),
        .q     (pwr_q)
    );

    csr_ctl_field #(.W(CACHE_W)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .wr    (sw_wr),
        .wdata (sw_wdata[PC_LSB +: CACHE_W]),
        .q     (pc_q)
    );

    csr_ctl_field #(.W(CACHE_W)) u_dc (
        .clk   (clk),
        .rst   (rst),
        .wr    (sw_wr),
        .wdata (sw_wdata[DC_LSB +: CACHE_W]),
        .q     (dc_q)
    );

    always_comb begin
        word.cpu_id  = CPU_ID;
        word.rev_id  = REV_ID;
        word.pwr_ctl = pwr_q;
        word.sat     = sat_q;
        word.endian  = endian_pin;
        word.pcache  = pc_q;
        word.dcache  = dc_q;
        word.ie_prev = ie_prev;
        word.ie_en   = ie_en;
    end

    assign sw_rdata = word;
    assign irq_en_o = ie_en;

endmodule

// File: rtl/core_ctrl_status_chk.sv
module core_ctrl_status_chk (
    input logic        clk,
    input logic        rst,
    input logic        sw_wr,
    input logic [31:0] sw_wdata,
    input logic [31:0] sw_rdata,
    input logic        irq_take,
    input logic        irq_ret,
    input logic        sat_set,
    input logic        irq_en_o
);

    // R3: the core never accepts and returns in the same cycle
    p_take_ret_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(irq_take && irq_ret));

    p_take_clears_r3: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !irq_en_o);

    p_take_saves_r3: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> sw_rdata[1] == $past(sw_rdata[0]));

    p_ret_restores_r4: assert property (@(posedge clk) disable iff (rst)
        (irq_ret && !irq_take) |=>
            (sw_rdata[0] == $past(sw_rdata[1])) && $stable(sw_rdata[1]));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!sw_wr && !irq_take && !irq_ret) |=> $stable(sw_rdata[1:0]));

    p_sat_no_sw_set_r8: assert property (@(posedge clk) disable iff (rst)
        (!sw_rdata[9] && !sat_set) |=> !sw_rdata[9]);

    p_sat_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
        sat_set |=> sw_rdata[9]);

    p_sat_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && !sw_wdata[9] && !sat_set) |=> !sw_rdata[9]);

    p_write_low_r5: assert property (@(posedge clk) disable iff (rst)
        (sw_wr && !irq_take && !irq_ret) |=>
            (sw_rdata[15:10] == $past(sw_wdata[15:10])) &&
            (sw_rdata[7:0] == {$past(sw_wdata[7:2]), $past(sw_wdata[1:0])}));

endmodule

bind core_ctrl_status core_ctrl_status_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .sw_wr    (sw_wr),
    .sw_wdata (sw_wdata),
    .sw_rdata (sw_rdata),
    .irq_take (irq_take),
    .irq_ret  (irq_ret),
    .sat_set  (sat_set),
    .irq_en_o (irq_en_o)
);

// File: tb/core_ctrl_status_tb.sv
module core_ctrl_status_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        sw_wr;
    logic [31:0] sw_wdata;
    logic [31:0] sw_rdata;
    logic        irq_take;
    logic        irq_ret;
    logic        sat_set;
    logic        endian_pin;
    logic        irq_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    core_ctrl_status #(.CPU_ID(8'hA5), .REV_ID(8'h3C)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .sw_wr      (sw_wr),
        .sw_wdata   (sw_wdata),
        .sw_rdata   (sw_rdata),
        .irq_take   (irq_take),
        .irq_ret    (irq_ret),
        .sat_set    (sat_set),
        .endian_pin (endian_pin),
        .irq_en_o   (irq_en_o)
    );

    typedef struct packed {
        logic        wr;
        logic [31:0] wd;
        logic        take;
        logic        ret;
        logic        sset;
        logic        endn;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA53C_FCFF, 4'd5},  // R5 R6 R8
        '{1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 32'hA53C_FFFF, 4'd9},  // R9 R7
        '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 32'hA53C_FFFE, 4'd3},  // R3
        '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 32'hA53C_FFFF, 4'd4},  // R4
        '{1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA53C_0000, 4'd8},  // R8 clear
        '{1'b1, 32'h0000_0001, 1'b0, 1'b0, 1'b1, 1'b0, 32'hA53C_0201, 4'd9},  // R9 set beats clear
        '{1'b1, 32'h0000_0002, 1'b1, 1'b0, 1'b0, 1'b0, 32'hA53C_0002, 4'd3},  // R3 beats write
        '{1'b1, 32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b0, 32'hA53C_0003, 4'd4},  // R4 beats write
        '{1'b0, 32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b1, 32'hA53C_0103, 4'd10}, // R10 hold
        '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 32'hA53C_0102, 4'd3},  // R3
        '{1'b0, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 32'hA53C_0100, 4'd3},  // R3 while disabled
        '{1'b0, 32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b1, 32'hA53C_0100, 4'd4},  // R4 restores 0
        '{1'b1, 32'hFFFF_28AD, 1'b0, 1'b0, 1'b0, 1'b1, 32'hA53C_29AD, 4'd6},  // R6 R5 R7
        '{1'b1, 32'h0000_0200, 1'b0, 1'b0, 1'b0, 1'b0, 32'hA53C_0000, 4'd8}   // R8 no sw set
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input int req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        sw_wr    = 1'b0;
        sw_wdata = 32'h0;
        irq_take = 1'b0;
        irq_ret  = 1'b0;
        sat_set  = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        endian_pin = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R2: reset state
        check(sw_rdata, 32'hA53C_0000, 2, "reset word");
        check({31'b0, irq_en_o}, 32'h0, 2, "reset enable");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            sw_wr      = VECS[i].wr;
            sw_wdata   = VECS[i].wd;
            irq_take   = VECS[i].take;
            irq_ret    = VECS[i].ret;
            sat_set    = VECS[i].sset;
            endian_pin = VECS[i].endn;
            @(negedge clk);
            check(sw_rdata, VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
            // R1: enable output tracks bit 0
            check({31'b0, irq_en_o}, {31'b0, VECS[i].exp[0]}, 1, $sformatf("enable vector %0d", i));
        end

        // R7: endian bit follows pin without a clock edge
        idle_inputs();
        endian_pin = 1'b0;
        #1;
        check({31'b0, sw_rdata[8]}, 32'h0, 7, "endian low");
        endian_pin = 1'b1;
        #1;
        check({31'b0, sw_rdata[8]}, 32'h1, 7, "endian high");

        // R2: reset mid-run clears everything written before
        @(negedge clk);
        sw_wr = 1'b1; sw_wdata = 32'h0000_FEFF; sat_set = 1'b1;
        @(negedge clk);
        check(sw_rdata, 32'hA53C_FFFF, 5, "full write");
        idle_inputs();
        endian_pin = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(sw_rdata, 32'hA53C_0000, 2, "reset after use");
        check({31'b0, irq_en_o}, 32'h0, 2, "enable after reset");
        rst = 1'b0;

        // R10: several idle cycles keep bits 1:0
        sw_wr = 1'b1; sw_wdata = 32'h0000_0002;
        @(negedge clk);
        idle_inputs();
        repeat (3) @(negedge clk);
        check({30'b0, sw_rdata[1:0]}, 32'h2, 10, "idle hold");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule